// File: doc/BRIEF.md
# PS/2 Host Receiver with Inhibit Window

This block is the host side of one PS/2 keyboard or mouse port, receive direction only. The clock and data lines are open-drain. Between transfers the host pulls both low to keep the device quiet. When it is ready it lets both go and opens a listen window of bounded length. The device must begin a frame inside that window, or the host pulls the lines low again and reports a timeout.

The device drives the clock for each frame. Every falling clock edge carries one bit. The host takes the bit either in the first cycle after it sees the edge, or a programmable time later, part way into the clock-low phase. Early sampling suits devices that meet the usual set-up times. Late sampling tolerates devices whose data settles slowly after the edge. Both raw lines pass through a two-flop synchronizer and a short glitch filter before edge detection.

A frame that is accepted produces a byte, a one-cycle valid strobe and an interrupt request. A frame with a bad start, parity or stop bit, or one that stalls part way, produces an error strobe instead and leaves the last good byte in place. All delays are given in microseconds and converted to cycles from the system clock frequency parameter. After every outcome the host re-inhibits the device, so each listen window yields at most one result.

Top module: `ps2_host_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both line enables are 1 (lines held low), rx_valid, rx_err, rx_timeout and irq are 0, and rx_byte is 0.
- R2: Each inhibit period lasts exactly INHIBIT_US microseconds, converted to cycles as CLK_HZ/1000*INHIBIT_US/1000. Both enables are then released in the same cycle.
- R3: If no falling clock edge is detected within START_WAIT_US of release, rx_timeout pulses for one cycle exactly START_WAIT_US of cycles after the release. In that same cycle the lines are held low again and no byte is reported. An edge detected in the last window cycle starts a frame and wins over the timeout.
- R4: A frame has 11 bits: start (0), eight data bits with the least significant bit first, odd parity (the nine bits after the start hold an odd number of ones), and stop (1). A valid frame gives a one-cycle rx_valid pulse with the byte on rx_byte, and the lines are held low in that same cycle.
- R5: With sample_late = 0, each bit is taken in the cycle after the filtered falling clock edge is seen.
- R6: With sample_late = 1, each bit is taken LATE_US after the filtered falling edge. Data that changes during the first part of the clock-low phase is read at its later value.
- R7: A start bit of 1, a stop bit of 0, or a parity mismatch gives a one-cycle rx_err pulse instead of rx_valid, and rx_byte keeps its previous value.
- R8: If no falling clock edge arrives for STALL_US during a frame, rx_err pulses, the partial frame is dropped and the host inhibits again.
- R9: A low pulse on the clock line shorter than FILT cycles is ignored and does not start a frame.
- R10: irq is 1 exactly in the cycles where rx_valid, rx_err or rx_timeout is 1. At most one of those three is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Sensed level of the clock line |
| ps2_data_i | input | 1 | Sensed level of the data line |
| sample_late | input | 1 | 1 selects delayed sampling into the clock-low phase |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_data_oe | output | 1 | 1 pulls the data line low |
| rx_byte | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe: a byte was accepted |
| rx_err | output | 1 | One-cycle strobe: frame error or stall |
| rx_timeout | output | 1 | One-cycle strobe: listen window expired |
| irq | output | 1 | Interrupt request, set for any strobe |

## Verification
The expiry of the listen window and the first falling clock edge can land in the same cycle. The design gives the edge priority, so a frame begins rather than a timeout. The bench provokes this by starting the device's first falling edge at offsets that step two cycles at a time across the end of the window, allowing for the latency of the synchronizer and filter. It judges each attempt by its first outcome: exactly one of a byte or a timeout. Early offsets must give a byte and late offsets a timeout, and once a timeout has appeared no later offset may return to giving a byte.

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
  parameter int CLK_HZ        = 8_000_000,
  parameter int INHIBIT_US    = 100,
  parameter int START_WAIT_US = 108,
  parameter int LATE_US       = 16,
  parameter int STALL_US      = 2000,
  parameter int FILT          = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  input  logic       sample_late,
  output logic       ps2_clk_oe,
  output logic       ps2_data_oe,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err,
  output logic       rx_timeout,
  output logic       irq
);

  localparam int KHZ       = CLK_HZ / 1000;
  localparam int INH_CYC   = KHZ * INHIBIT_US / 1000;
  localparam int WIN_CYC   = KHZ * START_WAIT_US / 1000;
  localparam int DLY_CYC   = KHZ * LATE_US / 1000;
  localparam int STALL_CYC = KHZ * STALL_US / 1000;
  localparam int MAX_A     = (INH_CYC > WIN_CYC) ? INH_CYC : WIN_CYC;
  localparam int MAX_C     = (MAX_A > STALL_CYC) ? MAX_A : STALL_CYC;
  localparam int TW        = $clog2(MAX_C + 1);
  localparam int DW        = $clog2(DLY_CYC + 2);
  localparam int FW        = $clog2(FILT + 1);

  localparam logic [TW-1:0] INH_END   = TW'(INH_CYC - 1);
  localparam logic [TW-1:0] WIN_END   = TW'(WIN_CYC - 1);
  localparam logic [TW-1:0] STALL_END = TW'(STALL_CYC - 1);
  localparam logic [DW-1:0] DLY_END   = DW'(DLY_CYC);

  typedef enum logic [1:0] {S_INH, S_LISTEN, S_FRAME} st_t;

  logic [1:0] raw, flt;
  assign raw = {ps2_data_i, ps2_clk_i};

  genvar g;
  for (g = 0; g < 2; g++) begin : g_line
    logic [1:0]    sy;
    logic [FW-1:0] cnt;
    logic          fl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy  <= 2'b11;
        cnt <= '0;
        fl  <= 1'b1;
      end else begin
        sy <= {sy[0], raw[g]};
        if (sy[1] == fl) cnt <= '0;
        else if (cnt == FW'(FILT - 1)) begin
          fl  <= sy[1];
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign flt[g] = fl;
  end

  st_t           st;
  logic [TW-1:0] tmr;
  logic [DW-1:0] dcnt;
  logic [3:0]    bitn;
  logic [10:0]   shreg;
  logic          hold_lo, pend, clk_q;

  logic        fall, take, good;
  logic [10:0] frame_w;

  assign fall    = clk_q & ~flt[0];
  assign take    = (st == S_FRAME) & pend & (sample_late ? (dcnt == DLY_END) : 1'b1);
  assign frame_w = {flt[1], shreg[10:1]};
  assign good    = ~frame_w[0] & frame_w[10] & (^frame_w[9:1]);

  assign ps2_clk_oe  = hold_lo;
  assign ps2_data_oe = hold_lo;
  assign irq         = rx_valid | rx_err | rx_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_INH;
      tmr        <= '0;
      dcnt       <= '0;
      bitn       <= '0;
      shreg      <= '0;
      hold_lo    <= 1'b1;
      pend       <= 1'b0;
      clk_q      <= 1'b1;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      rx_err     <= 1'b0;
      rx_timeout <= 1'b0;
    end else begin
      clk_q      <= flt[0];
      rx_valid   <= 1'b0;
      rx_err     <= 1'b0;
      rx_timeout <= 1'b0;
      case (st)
        S_INH: begin
          hold_lo <= 1'b1;
          if (tmr == INH_END) begin
            st      <= S_LISTEN;
            tmr     <= '0;
            hold_lo <= 1'b0;
          end else tmr <= tmr + 1'b1;
        end
        S_LISTEN: begin
          if (fall) begin
            st   <= S_FRAME;
            tmr  <= '0;
            bitn <= '0;
            pend <= 1'b1;
            dcnt <= '0;
          end else if (tmr == WIN_END) begin
            rx_timeout <= 1'b1;
            st         <= S_INH;
            tmr        <= '0;
            hold_lo    <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        S_FRAME: begin
          if (take) begin
            shreg <= frame_w;
            pend  <= 1'b0;
            bitn  <= bitn + 1'b1;
          end else if (pend) dcnt <= dcnt + 1'b1;
          if (fall) begin
            pend <= 1'b1;
            dcnt <= '0;
            tmr  <= '0;
          end else tmr <= tmr + 1'b1;
          if (take && bitn == 4'd10) begin
            if (good) begin
              rx_byte  <= frame_w[8:1];
              rx_valid <= 1'b1;
            end else rx_err <= 1'b1;
            st      <= S_INH;
            tmr     <= '0;
            pend    <= 1'b0;
            hold_lo <= 1'b1;
          end else if (!fall && tmr == STALL_END) begin
            rx_err  <= 1'b1;
            st      <= S_INH;
            tmr     <= '0;
            pend    <= 1'b0;
            hold_lo <= 1'b1;
          end
        end
        default: begin
          st      <= S_INH;
          tmr     <= '0;
          hold_lo <= 1'b1;
        end
      endcase
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));

  // R3
  tmo_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> $past(!ps2_clk_oe));

  // R4
  evt_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || rx_err || rx_timeout) |-> (ps2_clk_oe && ps2_data_oe));

  // R10
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_err, rx_timeout}));

  // R8
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRAME) |-> (tmr <= STALL_END));

  // R2
  release_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> $past(st == S_INH));

endmodule

// File: tb/ps2_host_rx_tb_top.sv
module ps2_host_rx_tb_top;
  localparam int CLK_HZ = 4_000_000;
  localparam int INH    = 80;
  localparam int WIN    = 432;
  localparam int STALL  = 1200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1, sample_late = 1'b0;
  logic ps2_clk_oe, ps2_data_oe, rx_valid, rx_err, rx_timeout, irq;
  logic [7:0] rx_byte;
  logic line_clk, line_dat;

  assign line_clk = dev_clk & ~ps2_clk_oe;
  assign line_dat = dev_dat & ~ps2_data_oe;

  always #2.5 clk = ~clk;

  ps2_host_rx #(.CLK_HZ(CLK_HZ), .INHIBIT_US(20), .START_WAIT_US(108),
    .LATE_US(16), .STALL_US(300), .FILT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(line_clk), .ps2_data_i(line_dat),
    .sample_late(sample_late), .ps2_clk_oe(ps2_clk_oe), .ps2_data_oe(ps2_data_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
    .rx_timeout(rx_timeout), .irq(irq));

  int checks = 0, errors = 0;
  int nv = 0, ne = 0, nt = 0, first_kind = 0, irq_bad = 0, cyc = 0, last_fall = 0;
  logic [7:0] got_byte = '0;
  bit sending = 0, inh_seen = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (first_kind == 0)
        first_kind = rx_valid ? 1 : rx_err ? 2 : rx_timeout ? 3 : 0;
      if (rx_valid) begin nv++; got_byte = rx_byte; end
      if (rx_err) ne++;
      if (rx_timeout) nt++;
      if (irq !== (rx_valid | rx_err | rx_timeout)) irq_bad++;
      if (sending && ps2_clk_oe) inh_seen = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_ev();
    nv = 0; ne = 0; nt = 0; first_kind = 0;
  endtask

  task automatic wait_release();
    do @(negedge clk); while (!ps2_clk_oe);
    do @(negedge clk); while (ps2_clk_oe);
    clear_ev();
  endtask

  task automatic wait_event(input int cap);
    for (int i = 0; i < cap; i++) begin
      if (nv + ne + nt > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit bad_start, input bit bad_par,
                      input bit bad_stop, input logic [7:0] mask,
                      input int nbits, input int lead);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
    sending = 1; inh_seen = 0;
    for (int i = 0; i < nbits; i++) begin
      if (inh_seen) break;
      dev_dat = fr[i] ^ ((i >= 1 && i <= 8) ? mask[i-1] : 1'b0);
      repeat (i == 0 ? lead : 40) @(negedge clk);
      dev_clk = 1'b0; last_fall = cyc;
      repeat (20) @(negedge clk);
      dev_dat = fr[i];
      repeat (60) @(negedge clk);
      dev_clk = 1'b1;
      repeat (40) @(negedge clk);
    end
    dev_dat = 1'b1; dev_clk = 1'b1; sending = 0;
  endtask

  initial begin
    int cnt;
    logic [7:0] prev;
    int tmo_seen;
    repeat (10) @(negedge clk);
    chk(ps2_clk_oe && ps2_data_oe && !rx_valid && !rx_err && !rx_timeout && !irq && rx_byte == 0,
        "R1", "state in reset", {ps2_clk_oe, rx_valid, rx_err, rx_timeout, irq}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ps2_clk_oe && !irq && rx_byte == 0, "R1", "state after reset", ps2_clk_oe, 1);
    cnt = 1;
    while (ps2_clk_oe) begin @(negedge clk); cnt++; end
    chk(cnt == INH, "R2", "first inhibit length", cnt, INH);
    chk(!ps2_data_oe, "R2", "data released with clock", ps2_data_oe, 0);
    clear_ev();
    cnt = 0;
    while (!rx_timeout && cnt < 2000) begin @(negedge clk); cnt++; end
    chk(cnt == WIN, "R3", "timeout delay", cnt, WIN);
    chk(ps2_clk_oe && nv == 0, "R3", "reinhibit on timeout", ps2_clk_oe, 1);
    cnt = 0;
    while (ps2_clk_oe) begin @(negedge clk); cnt++; end
    chk(cnt == INH, "R2", "inhibit after timeout", cnt, INH);

    for (int m = 0; m < 2; m++) begin
      sample_late = (m == 1);
      for (int k = 0; k < 12; k++) begin
        logic [7:0] b, exp;
        b = (k == 11) ? 8'hFF : 8'(k * 23);
        exp = sample_late ? b : ~b;
        wait_release();
        send(b, 0, 0, 0, 8'hFF, 11, 200);
        wait_event(3000);
        chk(first_kind == 1 && got_byte == exp,
            sample_late ? "R6" : "R5", "swept byte", got_byte, exp);
      end
    end
    chk(ps2_clk_oe, "R4", "lines held after byte", ps2_clk_oe, 1);

    sample_late = 1'b1;
    prev = got_byte;
    for (int e = 0; e < 3; e++) begin
      wait_release();
      send(8'h3C, e == 0, e == 1, e == 2, 8'h00, 11, 200);
      wait_event(3000);
      chk(first_kind == 2 && nv == 0, "R7", "frame error strobe", first_kind, 2);
      chk(rx_byte == prev, "R7", "byte kept after error", rx_byte, prev);
    end

    wait_release();
    send(8'h5A, 0, 0, 0, 8'h00, 5, 200);
    wait_event(STALL + 500);
    cnt = cyc - last_fall;
    chk(first_kind == 2 && cnt >= STALL && cnt <= STALL + 15, "R8", "stall error delay", cnt, STALL);
    chk(ps2_clk_oe && rx_byte == prev, "R8", "inhibit and byte after stall", rx_byte, prev);

    wait_release();
    repeat (60) @(negedge clk);
    dev_clk = 1'b0; repeat (2) @(negedge clk); dev_clk = 1'b1;
    send(8'hA5, 0, 0, 0, 8'h00, 11, 100);
    wait_event(3000);
    chk(first_kind == 1 && got_byte == 8'hA5 && ne == 0, "R9", "glitch ignored", got_byte, 8'hA5);

    tmo_seen = 0;
    for (int off = 412; off <= 440; off += 2) begin
      wait_release();
      send(8'h81, 0, 0, 0, 8'h00, 11, off);
      wait_event(3000);
      chk(first_kind == 1 || first_kind == 3, "R3", "single outcome at boundary", first_kind, 1);
      if (off <= 418) chk(first_kind == 1, "R3", "edge inside window", first_kind, 1);
      if (off >= 436) chk(first_kind == 3, "R3", "edge after window", first_kind, 3);
      if (tmo_seen) chk(first_kind == 3, "R3", "monotonic boundary", first_kind, 3);
      if (first_kind == 3) tmo_seen = 1;
    end

    chk(irq_bad == 0, "R10", "irq matches strobes", irq_bad, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule